// File: doc/BRIEF.md
# Burst Dimming Sequencer with Soft Start and Fault Blanking

This block sets lamp brightness by switching the lamp on and off at a low repetition rate. A free-running sawtooth counter advances on a slow tick and is compared with a brightness code. The result is the chop signal, which is high for a fraction of each sawtooth period. A full-scale brightness code keeps the lamp on all the time.

Every on-period starts two saturating digital ramps from zero. The soft-start ramp caps the duty requested by the regulation loop, so the gate-drive duty climbs gradually at the start of every burst. The blanking ramp tells the fault logic when its under-voltage and under-current checks may begin. The blanking flag rises once the blanking ramp reaches three fifths of its full scale. The first burst after reset, or after enable rises, is marked internally. During that burst the blanking ramp advances only once every FIRST_DIV ticks, which gives a cold lamp a much longer window to strike.

Top module: `burst_dimmer`

## Requirements
- R1: While `enable` is high, `chop` is high exactly when `bright`, read as unsigned, is greater than the sawtooth count. While `enable` is low, `chop`, `duty_out` and `blank_done` are 0.
- R2: The sawtooth count is cleared while disabled. It advances by one on each clock edge where `tick` is high, and wraps after 2^SAW_W ticks. That period is the burst period.
- R3: On each edge where `chop` is low, both ramps are cleared to zero. While `chop` is low, `duty_out` and `blank_done` are 0. After reset all outputs are 0.
- R4: While `chop` is high, `duty_out` equals the smaller of `duty_req` and the soft-start level.
- R5: On each edge where `chop` and `tick` are both high, the soft-start level rises by SS_STEP. The slope is the same in every burst.
- R6: While `chop` is high, `blank_done` is 1 when the blanking level is at least floor(3·(2^BLANK_W−1)/5). With the default width of 4 that threshold is 9.
- R7: In the first burst, the blanking level rises by one on every FIRST_DIV-th tick seen while `chop` is high. The prescaler restarts with each burst. In later bursts the level rises by one on every such tick.
- R8: A `bright` value of all ones holds `chop` high for as long as `enable` is high, whatever the sawtooth count.
- R9: The first-burst marker is set by reset and while `enable` is low. It is cleared on the first falling edge of `chop` while enabled.
- R10: Both ramps saturate at their all-ones value and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low clears all state and re-arms the first burst |
| tick | input | 1 | Slow time-base strobe, one cycle wide |
| bright | input | SAW_W | Brightness code compared with the sawtooth |
| duty_req | input | DUTY_W | Duty requested by the regulation loop |
| chop | output | 1 | Burst on/off signal |
| duty_out | output | DUTY_W | Duty passed on to the gate drive after the soft-start cap |
| blank_done | output | 1 | High when the fault checks may act |

## Verification
The assertions assume that `tick` is a single-cycle strobe synchronous to `clk`. They also assume that `enable`, `bright` and `duty_req` change only between edges, so the chop value seen at an edge is the one that steers the ramps. The stimulus changes every input one nanosecond after a rising edge. It compares the outputs at the falling edge, once the combinational paths from `bright` and `duty_req` have settled. The ramp checks rely on `chop` staying high across several ticks. For that reason the brightness codes are held for whole sequences, and the sparse-tick sequence spaces strobes three clocks apart.

// File: rtl/burst_pkg.sv
package burst_pkg;

   // Saturating add of a step onto an unsigned level of width W.
   function automatic logic [31:0] sat_add(input logic [31:0] level,
                                           input logic [31:0] step,
                                           input logic [31:0] top);
      logic [32:0] sum;
      sum = {1'b0, level} + {1'b0, step};
      return (sum > {1'b0, top}) ? top : sum[31:0];
   endfunction

endpackage

// File: rtl/burst_saw.sv
module burst_saw #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         tick,
   input  logic [W-1:0] level,
   output logic         chop
);
   logic [W-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (!en)   count <= '0;
      else if (tick)  count <= count + W'(1);
   end

   // All ones forces the lamp on for good; otherwise compare with the sawtooth.
   assign chop = en && ((&level) || (level > count));
endmodule

// File: rtl/burst_ramp.sv
module burst_ramp #(
   parameter int W    = 8,
   parameter int STEP = 1,
   parameter int DIV  = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic         slow,
   output logic [W-1:0] level
);
   import burst_pkg::*;

   localparam logic [W-1:0] TOP = '1;

   logic step_en;

   generate
      if (STEP < 1 || STEP >= (1 << W)) begin : g_bad_step
         $error("burst_ramp: STEP out of range");
      end
      if (DIV > 1) begin : g_pre
         localparam int PW = $clog2(DIV);
         logic [PW-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            pre <= '0;
            else if (clr)          pre <= '0;
            else if (adv && slow)  pre <= (pre == PW'(DIV - 1)) ? '0 : pre + PW'(1);
         end
         assign step_en = adv && (!slow || (pre == PW'(DIV - 1)));
      end else begin : g_nopre
         // Without a divider the slow input simply holds the ramp.
         assign step_en = adv && !slow;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        level <= '0;
      else if (clr)      level <= '0;
      else if (step_en)  level <= W'(sat_add(32'(level), 32'(STEP), 32'(TOP)));
   end
endmodule

// File: rtl/burst_first.sv
module burst_first (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic chop,
   output logic first
);
   logic chop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first  <= 1'b1;
         chop_q <= 1'b0;
      end else if (!en) begin
         first  <= 1'b1;
         chop_q <= 1'b0;
      end else begin
         chop_q <= chop;
         if (chop_q && !chop) first <= 1'b0;
      end
   end
endmodule

// File: rtl/burst_dimmer.sv
module burst_dimmer #(
   parameter int SAW_W     = 8,
   parameter int DUTY_W    = 8,
   parameter int SS_STEP   = 4,
   parameter int BLANK_W   = 4,
   parameter int FIRST_DIV = 150
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tick,
   input  logic [SAW_W-1:0]  bright,
   input  logic [DUTY_W-1:0] duty_req,
   output logic              chop,
   output logic [DUTY_W-1:0] duty_out,
   output logic              blank_done
);
   localparam int unsigned          BL_FULL = (1 << BLANK_W) - 1;
   localparam logic [BLANK_W-1:0]   BL_THR  = BLANK_W'((BL_FULL * 3) / 5);
   localparam logic [BLANK_W-1:0]   BL_TOP  = '1;
   localparam logic [DUTY_W-1:0]    D_TOP   = '1;
   localparam logic [DUTY_W-1:0]    SS_LIM  = D_TOP - DUTY_W'(SS_STEP);

   generate
      if (SAW_W < 2)       begin : g_bad_saw   $error("burst_dimmer: SAW_W too small");   end
      if (BLANK_W < 3)     begin : g_bad_blank $error("burst_dimmer: BLANK_W too small"); end
      if (FIRST_DIV < 1)   begin : g_bad_div   $error("burst_dimmer: FIRST_DIV < 1");     end
   endgenerate

   logic                chop_i;
   logic                first;
   logic                adv;
   logic [DUTY_W-1:0]   ss_lvl;
   logic [BLANK_W-1:0]  bl_lvl;
   logic [DUTY_W-1:0]   capped;

   burst_saw #(.W(SAW_W)) u_saw (
      .clk(clk), .rst_n(rst_n), .en(enable), .tick(tick),
      .level(bright), .chop(chop_i)
   );

   burst_first u_first (
      .clk(clk), .rst_n(rst_n), .en(enable), .chop(chop_i), .first(first)
   );

   assign adv = chop_i && tick;

   burst_ramp #(.W(DUTY_W), .STEP(SS_STEP), .DIV(1)) u_soft (
      .clk(clk), .rst_n(rst_n), .clr(!chop_i), .adv(adv), .slow(1'b0),
      .level(ss_lvl)
   );

   burst_ramp #(.W(BLANK_W), .STEP(1), .DIV(FIRST_DIV)) u_blank (
      .clk(clk), .rst_n(rst_n), .clr(!chop_i), .adv(adv), .slow(first),
      .level(bl_lvl)
   );

   assign capped     = (duty_req < ss_lvl) ? duty_req : ss_lvl;
   assign chop       = chop_i;
   assign duty_out   = chop_i ? capped : '0;
   assign blank_done = chop_i && (bl_lvl >= BL_THR);

   // R3: an off edge leaves both ramps at zero
   a_r3_ramps_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !chop |=> (ss_lvl == '0) && (bl_lvl == '0));

   // R4: the gate-drive duty never exceeds the loop request
   a_r4_duty_capped: assert property (@(posedge clk) disable iff (!rst_n)
      duty_out <= duty_req);

   // R5: constant soft-start slope
   a_r5_soft_slope: assert property (@(posedge clk) disable iff (!rst_n)
      (chop && tick && (ss_lvl <= SS_LIM)) |=> ss_lvl == $past(ss_lvl) + DUTY_W'(SS_STEP));

   // R7: during the first burst the blanking ramp moves at most one step per edge
   a_r7_first_slow: assert property (@(posedge clk) disable iff (!rst_n)
      (chop && first && (bl_lvl != BL_TOP)) |=> bl_lvl <= $past(bl_lvl) + BLANK_W'(1));

   // R8: full-scale brightness keeps the lamp on
   a_r8_full_on: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && (&bright)) |-> chop);

   // R9: disabling re-arms the first-burst marker
   a_r9_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> first);

   // R10: ramps hold at full scale while the burst lasts
   a_r10_soft_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (chop && (ss_lvl == D_TOP)) |=> ss_lvl == D_TOP);
   a_r10_blank_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (chop && (bl_lvl == BL_TOP)) |=> bl_lvl == BL_TOP);
endmodule

// File: tb/sim_burst_dimmer.sv
`timescale 1ns/1ps
module sim_burst_dimmer;
   localparam int SAWN  = 256;
   localparam int DMAX  = 255;
   localparam int BMAX  = 15;
   localparam int THR   = 9;
   localparam int STEPV = 4;
   localparam int DIVV  = 150;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] bright = '0;
   logic [7:0] duty_req = '0;
   logic       chop;
   logic [7:0] duty_out;
   logic       blank_done;

   burst_dimmer u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
      .bright(bright), .duty_req(duty_req),
      .chop(chop), .duty_out(duty_out), .blank_done(blank_done)
   );

   always #2.5 clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   bit done_all = 0;
   string tag = "R3";

   // Reference state derived from the requirements
   int m_saw = 0, m_ss = 0, m_bl = 0, m_pre = 0;
   bit m_first = 1, m_chq = 0;

   bit   q_c[$];
   int   q_d[$];
   bit   q_b[$];
   string q_t[$];

   function automatic bit chop_of(int saw);
      return enable && (bright == 8'hFF || int'(bright) > saw);
   endfunction

   function automatic void model_edge();
      bit c;
      if (!rst_n || !enable) begin
         m_saw = 0; m_ss = 0; m_bl = 0; m_pre = 0; m_first = 1; m_chq = 0;
         return;
      end
      c = chop_of(m_saw);
      if (!c) begin
         m_ss = 0; m_bl = 0; m_pre = 0;
      end else if (tick) begin
         m_ss = (m_ss + STEPV > DMAX) ? DMAX : m_ss + STEPV;
         if (m_first) begin
            if (m_pre == DIVV - 1) begin
               m_pre = 0;
               if (m_bl < BMAX) m_bl++;
            end else m_pre++;
         end else if (m_bl < BMAX) m_bl++;
      end
      if (m_chq && !c) m_first = 0;
      m_chq = c;
      if (tick) m_saw = (m_saw + 1) % SAWN;
   endfunction

   // Driver: advance one clock, apply next inputs, push expected outputs
   task automatic step(input bit t, input bit en, input int br, input int rq, input bit rs);
      bit c;
      @(posedge clk);
      model_edge();
      #1;
      rst_n = rs; enable = en; tick = t; bright = 8'(br); duty_req = 8'(rq);
      if (!rst_n) begin
         m_saw = 0; m_ss = 0; m_bl = 0; m_pre = 0; m_first = 1; m_chq = 0;
      end
      c = chop_of(m_saw);
      q_c.push_back(c);
      q_d.push_back(c ? ((rq < m_ss) ? rq : m_ss) : 0);
      q_b.push_back(c && (m_bl >= THR));
      q_t.push_back(tag);
   endtask

   task automatic run(input int n, input int every, input bit en, input int br, input int rq);
      for (int i = 0; i < n; i++) step((i % every) == 0, en, br, rq, 1'b1);
   endtask

   // Monitor: pop and compare away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         if (q_c.size() > 0) begin
            bit ec, eb; int ed; string et;
            ec = q_c.pop_front(); ed = q_d.pop_front(); eb = q_b.pop_front(); et = q_t.pop_front();
            n_checks++;
            if (chop !== ec || int'(duty_out) != ed || blank_done !== eb) begin
               n_fail++;
               $display("FAIL %s chop/duty/done actual %b/%0d/%b expected %b/%0d/%b at %0t",
                        et, chop, duty_out, blank_done, ec, ed, eb, $time);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done_all) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R3: reset state, all outputs zero
      tag = "R3";
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 0, 0, 1'b0);
      // R1: disabled block stays dark even with full brightness
      tag = "R1";
      run(6, 1, 1'b0, 255, 200);
      // R5: soft-start slope in the first burst, full-scale brightness
      tag = "R5";
      run(60, 1, 1'b1, 255, 200);
      // R10: soft ramp saturates, duty held at request
      tag = "R10";
      run(60, 1, 1'b1, 255, 255);
      // R8: chop stays high across sawtooth wraps
      tag = "R8";
      run(300, 1, 1'b1, 255, 200);
      // R7: slow first blanking, done after 9*150 ticks of the burst
      tag = "R7";
      run(1100, 1, 1'b1, 255, 200);
      // R9: bursts now end; first marker clears, later blanking is fast
      tag = "R9";
      run(600, 1, 1'b1, 100, 180);
      // R6: threshold timing in normal bursts
      tag = "R6";
      run(300, 1, 1'b1, 40, 255);
      // R4: request below the ramp caps the duty
      tag = "R4";
      run(520, 1, 1'b1, 200, 60);
      // R2: sparse ticks stretch the sawtooth period
      tag = "R2";
      run(900, 3, 1'b1, 128, 150);
      // R1: zero brightness keeps the lamp off
      tag = "R1";
      run(100, 1, 1'b1, 0, 150);
      // R9: disable then enable re-arms the slow first burst
      tag = "R9";
      run(10, 1, 1'b0, 200, 150);
      run(800, 1, 1'b1, 200, 150);
      // R10: blanking ramp saturates in a long normal burst
      tag = "R10";
      run(600, 1, 1'b1, 254, 255);
      // R3: resetting mid-burst clears everything
      tag = "R3";
      for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 254, 255, 1'b0);
      run(40, 1, 1'b1, 254, 255);
      @(posedge clk);
      @(negedge clk);
      @(negedge clk);
      done_all = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule